// File: doc/BRIEF.md
# Secure-Only Configuration Register Access Gate

This block stands between two bus initiators and one shared bank of configuration registers. Index 0 is the processor port and index 1 is the fabric-to-host port. Each initiator has its own AXI4-Lite-style read and write channels. The gate decides, request by request, whether the request may reach the registers. The security bit of a request is bit 1 of its protection field: 0 means secure and 1 means non-secure. Each initiator also has a target-setting input, `tgt_ns[i]`, with the same encoding: 0 means the registers are secure as seen from that initiator, and 1 means they are non-secure.

A request is refused only when it is non-secure and its initiator's target setting is secure. The gate completes the handshakes of a refused request itself. It then returns SLVERR (2'b10) one cycle later, and a refused read carries data from a free-running LFSR. A refused request never appears on the downstream port. Accepted requests from the two initiators share the downstream port through a two-way round-robin arbiter and are forwarded with their fields unchanged. The downstream response is routed back to the initiator that issued the request.

Top module: `csr_sec_gate`

## Requirements
- R1: A request whose protection bit 1 is 0 (secure) is forwarded downstream, and so is a non-secure request when `tgt_ns` for its initiator is 1. Both complete with OKAY (2'b00).
- R2: A request whose protection bit 1 is 1 while `tgt_ns` for its initiator is 0 gets SLVERR (2'b10). The response valid rises in the cycle right after the address handshake.
- R3: A refused read or write never asserts any downstream valid. A refused write leaves the register contents unchanged.
- R4: `tgt_ns[0]` governs only initiator 0 and `tgt_ns[1]` governs only initiator 1.
- R5: A forwarded write reaches the downstream port with its address, write data, byte strobes and protection bits unchanged. Downstream valids and fields stay stable until accepted.
- R6: The downstream response code and read data are returned to the initiator that issued the request. Its response stays valid and stable until accepted.
- R7: A refused write has its address and data handshakes accepted together and gets exactly one write response. A refused read returns LFSR data that is never all zero and changes from one refused read to the next.
- R8: When both initiators wait with accepted requests and the downstream port is free, the initiator not granted most recently wins. After reset, initiator 0 wins first.
- R9: `tgt_ns` is sampled at the address handshake. A later change does not alter the decision for that request.
- R10: While reset is high and right after it, every valid on the initiator response channels and on the downstream request channels is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_ns | input | 2 | Per-initiator target setting, 0 secure, 1 non-secure |
| s_awvalid | input | 2 | Write address valid, per initiator |
| s_awready | output | 2 | Write address ready |
| s_awaddr | input | 2 x AW | Write address |
| s_awprot | input | 2 x 3 | Write protection, bit 1 is the security bit |
| s_wvalid | input | 2 | Write data valid |
| s_wready | output | 2 | Write data ready |
| s_wdata | input | 2 x DW | Write data |
| s_wstrb | input | 2 x DW/8 | Write byte strobes |
| s_bvalid | output | 2 | Write response valid |
| s_bready | input | 2 | Write response ready |
| s_bresp | output | 2 x 2 | Write response code |
| s_arvalid | input | 2 | Read address valid |
| s_arready | output | 2 | Read address ready |
| s_araddr | input | 2 x AW | Read address |
| s_arprot | input | 2 x 3 | Read protection, bit 1 is the security bit |
| s_rvalid | output | 2 | Read data valid |
| s_rready | input | 2 | Read data ready |
| s_rdata | output | 2 x DW | Read data |
| s_rresp | output | 2 x 2 | Read response code |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_awaddr | output | AW | Downstream write address |
| m_awprot | output | 3 | Downstream write protection |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_wdata | output | DW | Downstream write data |
| m_wstrb | output | DW/8 | Downstream byte strobes |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_bresp | input | 2 | Downstream write response code |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_araddr | output | AW | Downstream read address |
| m_arprot | output | 3 | Downstream read protection |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |
| m_rdata | input | DW | Downstream read data |
| m_rresp | input | 2 | Downstream read response code |

## Verification
A wrong latched decision shows up within one transaction. A request that should be refused either produces a downstream access, which shows as a rise in the downstream access count, or it lacks the SLVERR response in the very next cycle. A corrupt owner or arbitration pointer sends a response to the wrong initiator or makes the downstream grants come out in the wrong order. Either fault shows at the first contested grant after a lone request, because the response queue of an initiator then receives an item it did not expect. A stalled LFSR shows as two refused reads returning the same data.

// File: rtl/csr_sec_gate_pkg.sv
package csr_sec_gate_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {P_IDLE, P_FWD, P_RESP} port_st_t;
  typedef enum logic [1:0] {T_IDLE, T_ADDR, T_RESP} tgt_st_t;
endpackage

// File: rtl/csr_sec_gate_lfsr.sv
module csr_sec_gate_lfsr #(
  parameter int           W    = 32,
  parameter logic [W-1:0] SEED = W'(32'h6A09E667),
  parameter logic [W-1:0] TAPS = W'(32'h80200003)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q
);
  // Galois form, shifts right, advances every cycle
  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
  end

  // R7: the pattern source never locks up in the all-zero state
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (rst) q != '0);
endmodule

// File: rtl/csr_sec_gate_rr.sv
module csr_sec_gate_rr (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic       en,
  output logic [1:0] gnt
);
  logic pri;  // 1 favours initiator 1

  assign gnt[0] = en & req[0] & (~req[1] | ~pri);
  assign gnt[1] = en & req[1] & (~req[0] |  pri);

  always_ff @(posedge clk) begin
    if (rst)                pri <= 1'b0;
    else if (en && (|req))  pri <= gnt[0];
  end

  // R8: at most one winner, and a free target with a waiting request always grants
  p_gnt_onehot_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  p_gnt_free_r8:   assert property (@(posedge clk) disable iff (rst) (en && (|req)) |-> (|gnt));
endmodule

// File: rtl/csr_sec_gate_port.sv
module csr_sec_gate_port import csr_sec_gate_pkg::*; #(
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_ns,
  input  logic [DW-1:0] rnd,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [AW-1:0] s_awaddr,
  input  logic [2:0]    s_awprot,
  input  logic          s_wvalid,
  output logic          s_wready,
  input  logic [DW-1:0] s_wdata,
  input  logic [SW-1:0] s_wstrb,
  output logic          s_bvalid,
  input  logic          s_bready,
  output logic [1:0]    s_bresp,
  input  logic          s_arvalid,
  output logic          s_arready,
  input  logic [AW-1:0] s_araddr,
  input  logic [2:0]    s_arprot,
  output logic          s_rvalid,
  input  logic          s_rready,
  output logic [DW-1:0] s_rdata,
  output logic [1:0]    s_rresp,
  output logic          req_o,
  output logic          q_wr,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data,
  output logic [SW-1:0] q_strb,
  output logic [2:0]    q_prot,
  input  logic          gnt_i,
  input  logic          done_i,
  input  logic [1:0]    dn_resp,
  input  logic [DW-1:0] dn_rdata
);
  port_st_t st;
  logic     fail_q;
  logic     take_w, take_r, reject;

  // a write is taken only with address and data together; writes win over reads
  assign take_w    = (st == P_IDLE) && s_awvalid && s_wvalid;
  assign take_r    = (st == P_IDLE) && s_arvalid && !(s_awvalid && s_wvalid);
  assign s_awready = take_w;
  assign s_wready  = take_w;
  assign s_arready = take_r;
  assign reject    = (take_w ? s_awprot[1] : s_arprot[1]) && !tgt_ns;
  assign req_o     = (st == P_FWD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= P_IDLE;  fail_q <= 1'b0;  q_wr <= 1'b0;
      q_addr <= '0;  q_data <= '0;  q_strb <= '0;  q_prot <= '0;
      s_bvalid <= 1'b0;  s_rvalid <= 1'b0;
      s_bresp <= RESP_OKAY;  s_rresp <= RESP_OKAY;  s_rdata <= '0;
    end else begin
      case (st)
        P_IDLE: if (take_w || take_r) begin
          q_wr   <= take_w;
          fail_q <= reject;
          q_addr <= take_w ? s_awaddr : s_araddr;
          q_prot <= take_w ? s_awprot : s_arprot;
          q_data <= s_wdata;
          q_strb <= take_w ? s_wstrb : '0;
          if (reject) begin
            st       <= P_RESP;
            s_bvalid <= take_w;
            s_rvalid <= take_r;
            s_bresp  <= RESP_SLVERR;
            s_rresp  <= RESP_SLVERR;
            s_rdata  <= take_r ? rnd : '0;
          end else begin
            st <= P_FWD;
          end
        end
        P_FWD: if (done_i) begin
          st       <= P_RESP;
          s_bvalid <= q_wr;
          s_rvalid <= !q_wr;
          s_bresp  <= dn_resp;
          s_rresp  <= dn_resp;
          s_rdata  <= q_wr ? '0 : dn_rdata;
        end
        default: if ((s_bvalid && s_bready) || (s_rvalid && s_rready)) begin
          st       <= P_IDLE;
          s_bvalid <= 1'b0;
          s_rvalid <= 1'b0;
        end
      endcase
    end
  end

  // R2: a refused request is answered with SLVERR in the very next cycle
  p_fail_answer_r2: assert property (@(posedge clk) disable iff (rst)
    ((take_w || take_r) && reject) |=>
      ((s_bvalid && s_bresp == RESP_SLVERR) || (s_rvalid && s_rresp == RESP_SLVERR)));
  // R3: a refused request never wins the downstream port
  p_fail_no_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (fail_q && st != P_IDLE) |-> !gnt_i);
  // R6: responses hold until taken
  p_b_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
  p_r_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rresp) && $stable(s_rdata)));
  // R9: the decision taken at the handshake does not move while forwarding
  p_cfg_latched_r9: assert property (@(posedge clk) disable iff (rst)
    (st == P_FWD) |=> $stable(fail_q));
  // R7: never both response channels at once
  p_one_resp_r7: assert property (@(posedge clk) disable iff (rst) !(s_bvalid && s_rvalid));
endmodule

// File: rtl/csr_sec_gate.sv
module csr_sec_gate import csr_sec_gate_pkg::*; #(
  parameter int           AW        = 12,
  parameter int           DW        = 32,
  parameter logic [DW-1:0] LFSR_SEED = DW'(32'h6A09E667),
  localparam int          SW        = DW / 8,
  localparam int          NI        = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NI-1:0]          tgt_ns,
  input  logic [NI-1:0]          s_awvalid,
  output logic [NI-1:0]          s_awready,
  input  logic [NI-1:0][AW-1:0]  s_awaddr,
  input  logic [NI-1:0][2:0]     s_awprot,
  input  logic [NI-1:0]          s_wvalid,
  output logic [NI-1:0]          s_wready,
  input  logic [NI-1:0][DW-1:0]  s_wdata,
  input  logic [NI-1:0][SW-1:0]  s_wstrb,
  output logic [NI-1:0]          s_bvalid,
  input  logic [NI-1:0]          s_bready,
  output logic [NI-1:0][1:0]     s_bresp,
  input  logic [NI-1:0]          s_arvalid,
  output logic [NI-1:0]          s_arready,
  input  logic [NI-1:0][AW-1:0]  s_araddr,
  input  logic [NI-1:0][2:0]     s_arprot,
  output logic [NI-1:0]          s_rvalid,
  input  logic [NI-1:0]          s_rready,
  output logic [NI-1:0][DW-1:0]  s_rdata,
  output logic [NI-1:0][1:0]     s_rresp,
  output logic                   m_awvalid,
  input  logic                   m_awready,
  output logic [AW-1:0]          m_awaddr,
  output logic [2:0]             m_awprot,
  output logic                   m_wvalid,
  input  logic                   m_wready,
  output logic [DW-1:0]          m_wdata,
  output logic [SW-1:0]          m_wstrb,
  input  logic                   m_bvalid,
  output logic                   m_bready,
  input  logic [1:0]             m_bresp,
  output logic                   m_arvalid,
  input  logic                   m_arready,
  output logic [AW-1:0]          m_araddr,
  output logic [2:0]             m_arprot,
  input  logic                   m_rvalid,
  output logic                   m_rready,
  input  logic [DW-1:0]          m_rdata,
  input  logic [1:0]             m_rresp
);
  logic [DW-1:0]         rnd;
  logic [NI-1:0]         req, gnt, done, q_wr;
  logic [NI-1:0][AW-1:0] q_addr;
  logic [NI-1:0][DW-1:0] q_data;
  logic [NI-1:0][SW-1:0] q_strb;
  logic [NI-1:0][2:0]    q_prot;
  tgt_st_t               tst;
  logic                  own, own_wr, sel, t_free, t_hit;
  logic [1:0]            dn_resp;

  csr_sec_gate_lfsr #(.W(DW), .SEED(LFSR_SEED)) u_lfsr (.clk(clk), .rst(rst), .q(rnd));

  assign t_free = (tst == T_IDLE);
  csr_sec_gate_rr u_rr (.clk(clk), .rst(rst), .req(req), .en(t_free), .gnt(gnt));

  assign t_hit   = (tst == T_RESP) && (own_wr ? m_bvalid : m_rvalid);
  assign dn_resp = own_wr ? m_bresp : m_rresp;

  for (genvar g = 0; g < NI; g++) begin : g_port
    localparam logic IDX = 1'(g);
    assign done[g] = t_hit && (own == IDX);
    csr_sec_gate_port #(.AW(AW), .DW(DW)) u_port (
      .clk(clk), .rst(rst), .tgt_ns(tgt_ns[g]), .rnd(rnd),
      .s_awvalid(s_awvalid[g]), .s_awready(s_awready[g]), .s_awaddr(s_awaddr[g]),
      .s_awprot(s_awprot[g]), .s_wvalid(s_wvalid[g]), .s_wready(s_wready[g]),
      .s_wdata(s_wdata[g]), .s_wstrb(s_wstrb[g]), .s_bvalid(s_bvalid[g]),
      .s_bready(s_bready[g]), .s_bresp(s_bresp[g]), .s_arvalid(s_arvalid[g]),
      .s_arready(s_arready[g]), .s_araddr(s_araddr[g]), .s_arprot(s_arprot[g]),
      .s_rvalid(s_rvalid[g]), .s_rready(s_rready[g]), .s_rdata(s_rdata[g]),
      .s_rresp(s_rresp[g]), .req_o(req[g]), .q_wr(q_wr[g]), .q_addr(q_addr[g]),
      .q_data(q_data[g]), .q_strb(q_strb[g]), .q_prot(q_prot[g]), .gnt_i(gnt[g]),
      .done_i(done[g]), .dn_resp(dn_resp), .dn_rdata(m_rdata)
    );
  end

  assign sel      = gnt[1];
  assign m_bready = (tst == T_RESP) && own_wr;
  assign m_rready = (tst == T_RESP) && !own_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tst <= T_IDLE;  own <= 1'b0;  own_wr <= 1'b0;
      m_awvalid <= 1'b0;  m_wvalid <= 1'b0;  m_arvalid <= 1'b0;
      m_awaddr <= '0;  m_araddr <= '0;  m_awprot <= '0;  m_arprot <= '0;
      m_wdata <= '0;  m_wstrb <= '0;
    end else begin
      case (tst)
        T_IDLE: if (|gnt) begin
          tst       <= T_ADDR;
          own       <= sel;
          own_wr    <= q_wr[sel];
          m_awvalid <= q_wr[sel];
          m_wvalid  <= q_wr[sel];
          m_arvalid <= !q_wr[sel];
          m_awaddr  <= q_addr[sel];
          m_araddr  <= q_addr[sel];
          m_awprot  <= q_prot[sel];
          m_arprot  <= q_prot[sel];
          m_wdata   <= q_data[sel];
          m_wstrb   <= q_strb[sel];
        end
        T_ADDR: begin
          if (m_awready) m_awvalid <= 1'b0;
          if (m_wready)  m_wvalid  <= 1'b0;
          if (m_arready) m_arvalid <= 1'b0;
          if ((!m_awvalid || m_awready) && (!m_wvalid || m_wready) &&
              (!m_arvalid || m_arready))
            tst <= T_RESP;
        end
        default: if (t_hit) tst <= T_IDLE;
      endcase
    end
  end

  // R5: forwarded fields hold until the target takes them
  p_aw_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awprot)));
  p_w_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));
  // R3: only one transaction downstream at a time
  p_one_kind_r3: assert property (@(posedge clk) disable iff (rst) !(m_awvalid && m_arvalid));
  // R6: a downstream completion is delivered to exactly one initiator
  p_done_one_r6: assert property (@(posedge clk) disable iff (rst) t_hit |-> $onehot(done));
endmodule

// File: tb/csr_sec_gate_bench.sv
`timescale 1ns/1ps
module csr_sec_gate_bench;
  localparam int AW = 12;
  localparam int DW = 32;

  typedef struct {
    bit          wr;
    bit          fl;
    logic [31:0] data;
    int          cyc;
    logic [31:0] tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [1:0]          tgt_ns = 2'b00;
  logic [1:0]          awvalid = '0, wvalid = '0, arvalid = '0;
  logic [1:0][AW-1:0]  awaddr = '0, araddr = '0;
  logic [1:0][2:0]     awprot = '0, arprot = '0;
  logic [1:0][DW-1:0]  wdata = '0;
  logic [1:0][3:0]     wstrb = '0;
  logic [1:0]          bready = 2'b11, rready = 2'b11;
  logic [1:0]          awready, wready, bvalid, arready, rvalid;
  logic [1:0][1:0]     bresp, rresp;
  logic [1:0][DW-1:0]  rdata;

  logic          m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready;
  logic [AW-1:0] m_awaddr, m_araddr;
  logic [2:0]    m_awprot, m_arprot;
  logic [DW-1:0] m_wdata;
  logic [3:0]    m_wstrb;
  logic          m_bvalid, m_rvalid;
  logic [1:0]    m_bresp, m_rresp;
  logic [DW-1:0] m_rdata;

  csr_sec_gate u_csr_sec_gate (
    .clk(clk), .rst(rst), .tgt_ns(tgt_ns),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr), .s_awprot(awprot),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr), .s_arprot(arprot),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .m_awvalid(m_awvalid), .m_awready(1'b1), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
    .m_wvalid(m_wvalid), .m_wready(1'b1), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .m_arvalid(m_arvalid), .m_arready(1'b1), .m_araddr(m_araddr), .m_arprot(m_arprot),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
  );

  // ---------------- downstream register model ----------------
  logic [31:0]   tmem [16];
  logic [31:0]   nw;
  int            tcount;
  logic [AW-1:0] lg_awaddr;
  logic [31:0]   lg_wdata;
  logic [3:0]    lg_wstrb;
  logic [2:0]    lg_awprot;
  logic [AW-1:0] ar_log [$];

  always @(posedge clk) begin
    if (rst) begin
      m_bvalid <= 1'b0;  m_rvalid <= 1'b0;  m_bresp <= 2'b00;  m_rresp <= 2'b00;
      m_rdata <= '0;  tcount <= 0;
      for (int k = 0; k < 16; k++) tmem[k] <= '0;
    end else begin
      if (m_awvalid && m_wvalid) begin
        nw = tmem[m_awaddr[5:2]];
        for (int b = 0; b < 4; b++) if (m_wstrb[b]) nw[8*b +: 8] = m_wdata[8*b +: 8];
        tmem[m_awaddr[5:2]] <= nw;
        lg_awaddr <= m_awaddr;  lg_wdata <= m_wdata;
        lg_wstrb  <= m_wstrb;   lg_awprot <= m_awprot;
        m_bvalid <= 1'b1;  m_bresp <= 2'b00;  tcount <= tcount + 1;
      end else if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (m_arvalid) begin
        m_rvalid <= 1'b1;  m_rresp <= 2'b00;  m_rdata <= tmem[m_araddr[5:2]];
        ar_log.push_back(m_araddr);  tcount <= tcount + 1;
      end else if (m_rvalid && m_rready) m_rvalid <= 1'b0;
    end
  end

  // ---------------- scoreboard ----------------
  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t q0 [$];
  exp_t q1 [$];
  logic [31:0] rnd_log [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: responses are taken in the cycle they appear (ready tied high)
  exp_t e;
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst && (bvalid[i] || rvalid[i])) begin
        if ((i == 0 && q0.size() == 0) || (i == 1 && q1.size() == 0)) begin
          chk(1'b0, "R7 unexpected response", {30'd0, bvalid[i], rvalid[i]}, 32'd0);
        end else begin
          if (i == 0) e = q0.pop_front(); else e = q1.pop_front();
          chk(bvalid[i] == e.wr, $sformatf("%s channel", e.tag), {31'd0, bvalid[i]}, {31'd0, e.wr});
          if (e.fl) begin
            chk((e.wr ? bresp[i] : rresp[i]) == 2'b10, $sformatf("%s refused resp", e.tag),
                {30'd0, e.wr ? bresp[i] : rresp[i]}, 32'd2);
            chk(cyc == e.cyc, $sformatf("%s R2 refusal latency", e.tag), cyc, e.cyc);
            if (!e.wr) rnd_log.push_back(rdata[i]);
          end else begin
            chk((e.wr ? bresp[i] : rresp[i]) == 2'b00, $sformatf("%s R1 okay resp", e.tag),
                {30'd0, e.wr ? bresp[i] : rresp[i]}, 32'd0);
            if (!e.wr) chk(rdata[i] == e.data, $sformatf("%s R6 read data", e.tag), rdata[i], e.data);
          end
        end
      end
    end
  end

  // driver: issue one request, push what the monitor must see
  task automatic xfer(input int i, input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p, input bit fl,
                      input logic [31:0] ed, input logic [31:0] tag, input bit flip);
    exp_t x;
    @(negedge clk);
    if (wr) begin
      awvalid[i] = 1'b1; awaddr[i] = a; awprot[i] = p;
      wvalid[i] = 1'b1;  wdata[i] = d;  wstrb[i] = s;
    end else begin
      arvalid[i] = 1'b1; araddr[i] = a; arprot[i] = p;
    end
    forever begin
      #2;
      if (wr ? (awready[i] && wready[i]) : arready[i]) break;
      @(negedge clk);
    end
    @(posedge clk); #1;
    awvalid[i] = 1'b0; wvalid[i] = 1'b0; arvalid[i] = 1'b0;
    if (flip) tgt_ns[i] = ~tgt_ns[i];
    x = '{wr, fl, ed, cyc, tag};
    if (i == 0) q0.push_back(x); else q1.push_back(x);
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bvalid == 0 && rvalid == 0 && !m_awvalid && !m_wvalid && !m_arvalid, "R10 reset valids",
        {27'd0, bvalid, rvalid, m_arvalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(bvalid == 0 && rvalid == 0 && !m_awvalid && !m_arvalid, "R10 after reset",
        {28'd0, bvalid, rvalid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  int c0;
  initial begin
    do_reset();
    // R1, R6: secure write then read back, both targets secure
    xfer(0, 1, 12'h004, 32'h11223344, 4'hF, 3'b000, 0, 0, "R1", 0);
    xfer(0, 0, 12'h004, 0, 0, 3'b000, 0, 32'h11223344, "R6", 0);
    drain();
    // R2, R3, R7: refused read and refused write from the processor port
    c0 = tcount;
    xfer(0, 0, 12'h004, 0, 0, 3'b010, 1, 0, "R2", 0);
    xfer(0, 1, 12'h004, 32'hDEADBEEF, 4'hF, 3'b010, 1, 0, "R7", 0);
    drain();
    chk(tcount == c0, "R3 no downstream access", tcount, c0);
    xfer(0, 0, 12'h004, 0, 0, 3'b000, 0, 32'h11223344, "R3", 0);
    drain();
    // R7: refused reads give changing pseudo-random data
    rnd_log.delete();
    xfer(1, 0, 12'h004, 0, 0, 3'b110, 1, 0, "R7", 0);
    xfer(1, 0, 12'h004, 0, 0, 3'b010, 1, 0, "R7", 0);
    drain();
    chk(rnd_log.size() == 2, "R7 refused read count", rnd_log.size(), 2);
    if (rnd_log.size() == 2) begin
      chk(rnd_log[0] != rnd_log[1], "R7 data changes", rnd_log[1], ~rnd_log[0]);
      chk(rnd_log[0] != 0, "R7 data nonzero", rnd_log[0], 32'hFFFFFFFF);
    end
    // R4, R5: processor side opened, fabric side still secure
    tgt_ns = 2'b01;
    xfer(0, 1, 12'h008, 32'hAABBCCDD, 4'b0101, 3'b011, 0, 0, "R5", 0);
    drain();
    chk(lg_awaddr == 12'h008, "R5 address", {20'd0, lg_awaddr}, 32'h008);
    chk(lg_wdata == 32'hAABBCCDD, "R5 data", lg_wdata, 32'hAABBCCDD);
    chk(lg_wstrb == 4'b0101, "R5 strobe", {28'd0, lg_wstrb}, 32'h5);
    chk(lg_awprot == 3'b011, "R5 prot", {29'd0, lg_awprot}, 32'h3);
    c0 = tcount;
    xfer(1, 0, 12'h008, 0, 0, 3'b010, 1, 0, "R4", 0);
    drain();
    chk(tcount == c0, "R4 fabric still blocked", tcount, c0);
    tgt_ns = 2'b10;
    xfer(1, 0, 12'h008, 0, 0, 3'b010, 0, 32'h00BB00DD, "R4", 0);
    xfer(0, 0, 12'h008, 0, 0, 3'b010, 1, 0, "R4", 0);
    drain();
    // R9: setting changes right after the handshake do not alter the decision
    tgt_ns = 2'b01;
    xfer(0, 0, 12'h008, 0, 0, 3'b010, 0, 32'h00BB00DD, "R9", 1);
    drain();
    xfer(0, 0, 12'h008, 0, 0, 3'b010, 1, 0, "R9", 1);
    drain();
    // R8: round robin after a lone grant
    tgt_ns = 2'b00;
    do_reset();
    xfer(0, 0, 12'h010, 0, 0, 3'b000, 0, 0, "R8", 0);
    drain();
    ar_log.delete();
    fork
      xfer(0, 0, 12'h014, 0, 0, 3'b000, 0, 0, "R8", 0);
      xfer(1, 0, 12'h024, 0, 0, 3'b000, 0, 0, "R8", 0);
    join
    drain();
    chk(ar_log.size() == 2 && ar_log[0] == 12'h024, "R8 fabric wins after processor",
        ar_log.size() > 0 ? {20'd0, ar_log[0]} : 32'd0, 32'h024);
    xfer(1, 0, 12'h020, 0, 0, 3'b000, 0, 0, "R8", 0);
    drain();
    ar_log.delete();
    fork
      xfer(0, 0, 12'h018, 0, 0, 3'b000, 0, 0, "R8", 0);
      xfer(1, 0, 12'h028, 0, 0, 3'b000, 0, 0, "R8", 0);
    join
    drain();
    chk(ar_log.size() == 2 && ar_log[0] == 12'h018, "R8 processor wins after fabric",
        ar_log.size() > 0 ? {20'd0, ar_log[0]} : 32'd0, 32'h018);
    finish_run();
  end
endmodule